// File: doc/BRIEF.md
# Relocatable On-Chip RAM Window Decoder

This block sits on a 24-bit, byte-wide processor bus and claims two adjacent 8 KB windows for on-chip RAM. A programmable page register picks which 64 KB page holds the windows. Inside that page, the top 8 KB is a zero-wait general-purpose RAM. The 8 KB just below it is a second RAM that is reached through a shared-bus arbiter, which is modelled here by a single grant input. While the windows are enabled, a RAM hit beats the flash decode and the external chip-select decodes that other logic computes for the same address. Those lower-priority selects enter the block and leave it masked.

The block holds the byte storage for both windows. Each access is a read or a write strobe held together with its address until the block raises ready. For the general-purpose window, ready rises in the first cycle. For the arbitrated window, ready waits for the grant and, when the slow-mode input is high, for at least one extra cycle. The storage depth for each window is a parameter. The 13-bit window offset is XOR-folded onto that depth, so a depth below 8 KB mirrors, and a depth of 8 KB maps each byte one to one.

Top module: `ramwin_top`

## Requirements
- R1: After reset the page register holds 8'hFF and the windows are enabled, so address 24'hFFE000 selects the general-purpose window and 24'hFFC000 selects the arbitrated window.
- R2: With page P, addresses {P,16'hE000} through {P,16'hFFFF} raise gp_hit, and {P,16'hDFFF} or an address in any other page does not.
- R3: With page P, addresses {P,16'hC000} through {P,16'hDFFF} raise aux_hit, and {P,16'hBFFF} does not.
- R4: A read or write that hits the general-purpose window sees ram_ready high in the same cycle the strobe is first presented, with no wait state.
- R5: In fast mode (aux_slow=0) an arbitrated-window access with the grant already high completes in its first cycle. While the access is outstanding, aux_req stays high and ram_ready stays low for as long as the grant is low.
- R6: In slow mode (aux_slow=1) an arbitrated-window access with the grant high from the start completes with exactly one wait state.
- R7: When the grant arrives late, ram_ready stays low until the first cycle with the grant high and then rises in that cycle, provided the slow-mode wait has already elapsed.
- R8: While gp_hit or aux_hit is high, flash_sel_out and every bit of cs_sel_out are 0. Otherwise they copy flash_sel_in and cs_sel_in.
- R9: Writing 0 through en_we disables both windows: no hit, no ready, and the flash and chip-select inputs pass through unmasked.
- R10: A page-register write leaves the decode unchanged in the cycle of the write and moves both windows to the new page from the next cycle onward.
- R11: A read returns on bus_rdata, in its ready cycle, the byte last written to that address. The two windows keep separate bytes at the same offset.
- R12: Storage changes only in a cycle where a window is selected, the write strobe is high and ready is high. A write strobe to a disabled window and any read leave the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write strobe for the page register |
| base_wdata | input | 8 | New page value |
| en_we | input | 1 | Write strobe for the window enable |
| en_wdata | input | 1 | New enable value |
| bus_addr | input | 24 | Byte address |
| bus_rd | input | 1 | Read strobe, held until ready |
| bus_wr | input | 1 | Write strobe, held until ready |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the ready cycle of a read |
| ram_ready | output | 1 | Access to a RAM window completes this cycle |
| gp_hit | output | 1 | Address decodes to the general-purpose window |
| aux_hit | output | 1 | Address decodes to the arbitrated window |
| aux_req | output | 1 | Request to the arbiter for an arbitrated-window access |
| arb_grant | input | 1 | Grant from the arbiter |
| aux_slow | input | 1 | 1 adds one wait state to arbitrated-window accesses |
| flash_sel_in | input | 1 | Flash select from the flash decoder |
| cs_sel_in | input | 4 | External chip selects from their decoders |
| flash_sel_out | output | 1 | Flash select after RAM priority |
| cs_sel_out | output | 4 | Chip selects after RAM priority |

## Verification
The assertions take three things for granted. A master never raises read and write together. It holds address, strobes and data stable from the first cycle of an access until ready. Every strobe and configuration input is low while reset is applied. The one-wait property in slow mode also assumes that each arbitrated access follows at least one idle cycle. The bench keeps within all of this: its access task drives every input on the falling edge, holds it until it samples ready, and then returns the bus to idle for one cycle. It changes aux_slow and the grant only between accesses or as the scheduled grant arrives.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;

    localparam int ADDR_W    = 24;
    localparam int PAGE_LO   = 16;
    localparam int REGION_AW = 13;
    localparam int BASE_W    = ADDR_W - PAGE_LO;
    localparam int SUB_W     = PAGE_LO - REGION_AW;
    localparam int HI_W      = ADDR_W - REGION_AW;

    localparam logic [BASE_W-1:0] BASE_RESET = {BASE_W{1'b1}};
    localparam logic [SUB_W-1:0]  SUB_GP     = {SUB_W{1'b1}};
    localparam logic [SUB_W-1:0]  SUB_AUX    = {SUB_W{1'b1}} - 1'b1;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_GP   = 2'd1,
        RGN_AUX  = 2'd2
    } rgn_e;

    typedef struct packed {
        logic [BASE_W-1:0] page;
        logic              en;
    } win_cfg_t;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    // Classify the address bits above the window offset.
    function automatic rgn_e classify(input logic [HI_W-1:0] hi, input win_cfg_t cfg);
        logic [BASE_W-1:0] page;
        logic [SUB_W-1:0]  sub;
        rgn_e              r;
        page = hi[HI_W-1:SUB_W];
        sub  = hi[SUB_W-1:0];
        r    = RGN_NONE;
        if (cfg.en && (page == cfg.page)) begin
            if (sub == SUB_GP)
                r = RGN_GP;
            else if (sub == SUB_AUX)
                r = RGN_AUX;
        end
        return r;
    endfunction

endpackage

// File: rtl/ramwin_cfg.sv
module ramwin_cfg
    import ramwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              en_we,
    input  logic              en_wdata,
    output win_cfg_t          cfg
);

    win_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.page <= BASE_RESET;
            cfg_q.en   <= 1'b1;
        end else begin
            if (base_we)
                cfg_q.page <= base_wdata;
            if (en_we)
                cfg_q.en <= en_wdata;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/ramwin_decode.sv
module ramwin_decode
    import ramwin_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  win_cfg_t          cfg,
    input  logic              flash_in,
    input  logic [NUM_CS-1:0] cs_in,
    output rgn_e              rgn,
    output logic              flash_out,
    output logic [NUM_CS-1:0] cs_out
);

    logic ram_claim;

    always_comb begin
        rgn       = classify(addr[ADDR_W-1:REGION_AW], cfg);
        ram_claim = (rgn != RGN_NONE);
    end

    assign flash_out = flash_in & ~ram_claim;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs_mask
        assign cs_out[g] = cs_in[g] & ~ram_claim;
    end

endmodule

// File: rtl/ramwin_wait.sv
module ramwin_wait (
    input  logic clk,
    input  logic rst,
    input  logic acc,
    input  logic slow,
    input  logic grant,
    output logic ready
);

    // Set once an arbitrated access has spent a cycle without completing.
    logic waited_q;

    always_comb begin
        ready = acc & grant & (slow ? waited_q : 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            waited_q <= 1'b0;
        else
            waited_q <= acc & ~ready;
    end

endmodule

// File: rtl/ramwin_store.sv
module ramwin_store
    import ramwin_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STORE_AW = 11
) (
    input  logic                 clk,
    input  logic                 we,
    input  logic                 bank,
    input  logic [REGION_AW-1:0] off,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);

    localparam int IDX_W = STORE_AW + 1;
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0]   mem [DEPTH];
    logic [STORE_AW-1:0] fold;
    logic [IDX_W-1:0]    idx;

    // Fold the window offset onto the storage depth.
    always_comb begin
        fold = '0;
        for (int i = 0; i < REGION_AW; i++)
            fold[i % STORE_AW] = fold[i % STORE_AW] ^ off[i];
        idx = {bank, fold};
    end

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/ramwin_top.sv
module ramwin_top
    import ramwin_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int NUM_CS   = 4,
    parameter int STORE_AW = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic [BASE_W-1:0] base_wdata,
    input  logic              en_we,
    input  logic              en_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              ram_ready,
    output logic              gp_hit,
    output logic              aux_hit,
    output logic              aux_req,
    input  logic              arb_grant,
    input  logic              aux_slow,
    input  logic              flash_sel_in,
    input  logic [NUM_CS-1:0] cs_sel_in,
    output logic              flash_sel_out,
    output logic [NUM_CS-1:0] cs_sel_out
);

    win_cfg_t          cfg;
    rgn_e              rgn;
    strobe_t           stb;
    logic              acc;
    logic              gp_acc;
    logic              aux_acc;
    logic              aux_ready;
    logic              store_we;
    logic [DATA_W-1:0] store_rdata;
    logic [BASE_W-1:0] page_q;
    logic              en_q;

    ramwin_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .base_we    (base_we),
        .base_wdata (base_wdata),
        .en_we      (en_we),
        .en_wdata   (en_wdata),
        .cfg        (cfg)
    );

    assign page_q = cfg.page;
    assign en_q   = cfg.en;

    ramwin_decode #(.NUM_CS(NUM_CS)) u_dec (
        .addr      (bus_addr),
        .cfg       (cfg),
        .flash_in  (flash_sel_in),
        .cs_in     (cs_sel_in),
        .rgn       (rgn),
        .flash_out (flash_sel_out),
        .cs_out    (cs_sel_out)
    );

    always_comb begin
        stb.rd  = bus_rd;
        stb.wr  = bus_wr;
        acc     = stb.rd | stb.wr;
        gp_hit  = (rgn == RGN_GP);
        aux_hit = (rgn == RGN_AUX);
        gp_acc  = gp_hit & acc;
        aux_acc = aux_hit & acc;
    end

    ramwin_wait u_wait (
        .clk   (clk),
        .rst   (rst),
        .acc   (aux_acc),
        .slow  (aux_slow),
        .grant (arb_grant),
        .ready (aux_ready)
    );

    always_comb begin
        ram_ready = gp_acc | aux_ready;
        aux_req   = aux_acc;
        store_we  = ram_ready & stb.wr;
        bus_rdata = (ram_ready & stb.rd) ? store_rdata : '0;
    end

    ramwin_store #(.DATA_W(DATA_W), .STORE_AW(STORE_AW)) u_store (
        .clk   (clk),
        .we    (store_we),
        .bank  (gp_hit),
        .off   (bus_addr[REGION_AW-1:0]),
        .wdata (bus_wdata),
        .rdata (store_rdata)
    );

endmodule

// File: rtl/ramwin_chk.sv
module ramwin_chk
    import ramwin_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              gp_hit,
    input logic              aux_hit,
    input logic              ram_ready,
    input logic              arb_grant,
    input logic              aux_slow,
    input logic              flash_sel_out,
    input logic [NUM_CS-1:0] cs_sel_out,
    input logic              base_we,
    input logic [BASE_W-1:0] page_q,
    input logic              en_q
);

    logic acc_aux;
    assign acc_aux = aux_hit & (bus_rd | bus_wr);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (page_q == BASE_RESET) && en_q);

    p_gp_zero_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (gp_hit && (bus_rd || bus_wr)) |-> ram_ready);

    p_slow_first_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_aux && aux_slow && !$past(acc_aux)) |-> !ram_ready);

    p_needs_grant_r7: assert property (@(posedge clk) disable iff (rst)
        (aux_hit && ram_ready) |-> arb_grant);

    p_priority_r8: assert property (@(posedge clk) disable iff (rst)
        (gp_hit || aux_hit) |-> (!flash_sel_out && (cs_sel_out == '0)));

    p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> (!gp_hit && !aux_hit && !ram_ready));

    p_page_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(base_we) |-> $stable(page_q));

endmodule

bind ramwin_top ramwin_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .gp_hit        (gp_hit),
    .aux_hit       (aux_hit),
    .ram_ready     (ram_ready),
    .arb_grant     (arb_grant),
    .aux_slow      (aux_slow),
    .flash_sel_out (flash_sel_out),
    .cs_sel_out    (cs_sel_out),
    .base_we       (base_we),
    .page_q        (page_q),
    .en_q          (en_q)
);

// File: tb/ramwin_top_test.sv
`timescale 1ns/1ps
module ramwin_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_we = 1'b0;
    logic [7:0]  base_wdata = '0;
    logic        en_we = 1'b0;
    logic        en_wdata = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        ram_ready;
    logic        gp_hit;
    logic        aux_hit;
    logic        aux_req;
    logic        arb_grant = 1'b0;
    logic        aux_slow = 1'b0;
    logic        flash_sel_in = 1'b0;
    logic [3:0]  cs_sel_in = '0;
    logic        flash_sel_out;
    logic [3:0]  cs_sel_out;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    ramwin_top uut (
        .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
        .en_we(en_we), .en_wdata(en_wdata), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ram_ready(ram_ready), .gp_hit(gp_hit),
        .aux_hit(aux_hit), .aux_req(aux_req), .arb_grant(arb_grant),
        .aux_slow(aux_slow), .flash_sel_in(flash_sel_in), .cs_sel_in(cs_sel_in),
        .flash_sel_out(flash_sel_out), .cs_sel_out(cs_sel_out)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_map(input logic [23:0] a, input bit exp_gp, input bit exp_aux, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b0; bus_wr = 1'b0;
        #1;
        check(tag, $sformatf("gp_hit @%h", a), int'(gp_hit), int'(exp_gp));
        check(tag, $sformatf("aux_hit @%h", a), int'(aux_hit), int'(exp_aux));
    endtask

    // One access; returns waits (-1 on timeout) and the read byte.
    task automatic bus_op(input logic [23:0] a, input bit w, input logic [7:0] d,
                          input int gdelay, output int waits, output logic [7:0] rval);
        int  cyc  = 0;
        bit  done = 0;
        rval = '0;
        while (!done && cyc < 16) begin
            @(negedge clk);
            bus_addr = a; bus_rd = !w; bus_wr = w; bus_wdata = d;
            arb_grant = (cyc >= gdelay);
            #1;
            if (ram_ready) begin
                done = 1;
                rval = bus_rdata;
            end else begin
                cyc++;
            end
        end
        waits = done ? cyc : -1;
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; arb_grant = 1'b0;
    endtask

    task automatic t_reset;
        check_map(24'hFFE000, 1, 0, "R1");
        check_map(24'hFFC000, 0, 1, "R1");
    endtask

    task automatic t_ranges;
        check_map(24'hFFFFFF, 1, 0, "R2");
        check_map(24'hFFE000, 1, 0, "R2");
        check_map(24'hFFDFFF, 0, 1, "R2");
        check_map(24'hFEE000, 0, 0, "R2");
        check_map(24'hFFC000, 0, 1, "R3");
        check_map(24'hFFBFFF, 0, 0, "R3");
        check_map(24'h00C123, 0, 0, "R3");
    endtask

    task automatic t_priority;
        flash_sel_in = 1'b1; cs_sel_in = 4'b1011;
        check_map(24'hFFE100, 1, 0, "R8");
        check("R8", "flash masked", int'(flash_sel_out), 0);
        check("R8", "cs masked", int'(cs_sel_out), 0);
        check_map(24'hFFD100, 0, 1, "R8");
        check("R8", "cs masked aux", int'(cs_sel_out), 0);
        check_map(24'h123456, 0, 0, "R8");
        check("R8", "flash passes", int'(flash_sel_out), 1);
        check("R8", "cs passes", int'(cs_sel_out), 'hB);
        flash_sel_in = 1'b0; cs_sel_in = '0;
    endtask

    task automatic t_gp_access;
        int w; logic [7:0] r;
        bus_op(24'hFFE010, 1, 8'h5A, 0, w, r);
        check("R4", "gp write waits", w, 0);
        bus_op(24'hFFE010, 0, 8'h00, 0, w, r);
        check("R4", "gp read waits", w, 0);
        check("R11", "gp read data", int'(r), 'h5A);
    endtask

    task automatic t_aux_fast;
        int w; logic [7:0] r;
        aux_slow = 1'b0;
        bus_op(24'hFFC010, 1, 8'hC3, 0, w, r);
        check("R5", "aux fast write waits", w, 0);
        bus_op(24'hFFC010, 0, 8'h00, 0, w, r);
        check("R5", "aux fast read waits", w, 0);
        check("R11", "aux read data", int'(r), 'hC3);
        bus_op(24'hFFE010, 0, 8'h00, 0, w, r);
        check("R11", "gp byte separate from aux", int'(r), 'h5A);
        // grant withheld: request up, ready down
        @(negedge clk);
        bus_addr = 24'hFFC010; bus_rd = 1'b1; arb_grant = 1'b0;
        #1;
        check("R5", "aux_req while waiting", int'(aux_req), 1);
        check("R5", "no ready without grant", int'(ram_ready), 0);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic t_aux_slow;
        int w; logic [7:0] r;
        aux_slow = 1'b1;
        bus_op(24'hFFC020, 1, 8'h77, 0, w, r);
        check("R6", "slow write waits", w, 1);
        bus_op(24'hFFC020, 0, 8'h00, 0, w, r);
        check("R6", "slow read waits", w, 1);
        check("R6", "slow read data", int'(r), 'h77);
        aux_slow = 1'b0;
    endtask

    task automatic t_late_grant;
        int w; logic [7:0] r;
        aux_slow = 1'b0;
        bus_op(24'hFFC030, 1, 8'h3C, 3, w, r);
        check("R7", "fast late grant waits", w, 3);
        aux_slow = 1'b1;
        bus_op(24'hFFC030, 0, 8'h00, 2, w, r);
        check("R7", "slow late grant waits", w, 2);
        check("R7", "late grant data", int'(r), 'h3C);
        aux_slow = 1'b0;
    endtask

    task automatic t_relocate;
        int w; logic [7:0] r;
        @(negedge clk);
        base_we = 1'b1; base_wdata = 8'h7A; bus_addr = 24'h7AE000;
        #1;
        check("R10", "old page in write cycle", int'(gp_hit), 0);
        @(negedge clk);
        base_we = 1'b0;
        #1;
        check("R10", "new page next cycle", int'(gp_hit), 1);
        check_map(24'hFFE000, 0, 0, "R10");
        check_map(24'h7AC000, 0, 1, "R10");
        bus_op(24'h7AE040, 1, 8'h11, 0, w, r);
        bus_op(24'h7AE040, 0, 8'h00, 0, w, r);
        check("R10", "access at new page", int'(r), 'h11);
    endtask

    task automatic t_disable;
        int w; logic [7:0] r;
        @(negedge clk);
        en_we = 1'b1; en_wdata = 1'b0;
        @(negedge clk);
        en_we = 1'b0;
        flash_sel_in = 1'b1; cs_sel_in = 4'b0110;
        check_map(24'h7AE040, 0, 0, "R9");
        check("R9", "flash passes when off", int'(flash_sel_out), 1);
        check("R9", "cs passes when off", int'(cs_sel_out), 'h6);
        // write strobe at a disabled window
        @(negedge clk);
        bus_addr = 24'h7AE040; bus_wr = 1'b1; bus_wdata = 8'hEE;
        #1;
        check("R9", "no ready when off", int'(ram_ready), 0);
        @(negedge clk);
        bus_wr = 1'b0; flash_sel_in = 1'b0; cs_sel_in = '0;
        en_we = 1'b1; en_wdata = 1'b1;
        @(negedge clk);
        en_we = 1'b0;
        bus_op(24'h7AE040, 0, 8'h00, 0, w, r);
        check("R12", "disabled write ignored", int'(r), 'h11);
        bus_op(24'h7AE040, 0, 8'h00, 0, w, r);
        check("R12", "read leaves byte", int'(r), 'h11);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_ranges();
        t_priority();
        t_gp_access();
        t_aux_fast();
        t_aux_slow();
        t_late_grant();
        t_relocate();
        t_disable();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule